// File: doc/BRIEF.md
# Flash Operation Timing Sequencer

This block steps a non-volatile memory array through one operation at a time: a whole-array erase, a single-page erase, a program, an erase of the reference cell, or a recall of the trim code. Software writes a command bit into the command register. The sequencer then raises busy and runs three timed phases: setup, main and hold. It counts each phase in clock cycles, using lengths taken from packed fields in three timing registers. During the main phase it drives an erase strobe or a program strobe toward the array, together with an array address. After the hold phase it drops busy, clears the command bit and pulses done for one cycle.

The bus is a plain 32-bit register port. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`. The port has no flow control and never stalls. There is no streaming data path, so no valid/ready handshake exists. The array is modelled only by its strobes: the operation's end comes from the counters, and no reply from the array is awaited.

Register map (byte offsets): command 0x00, status 0x04, timing A 0x08, timing B 0x0C, timing C 0x10, address 0x14. Any other offset reads zero.

Top module: `nvm_op_sequencer`

## Requirements
- R1: After reset the command, status, timing and address registers read zero, and `busy`, `arr_erase`, `arr_prog` and `arr_done` are low.
- R2: A write to the command register while idle starts an operation if any of bits 7:3 is set. Bit 3 starts a mass erase, bit 4 a page erase, bit 5 a program, bit 6 a reference-cell erase and bit 7 a trim recall. When several of these bits are set, the lowest-numbered one wins. While the operation runs, the command register reads back only that bit. A write with none of bits 7:3 set starts nothing.
- R3: Busy (the `busy` pin and status bit 0) is high for exactly max(S,1)+max(M,1)+max(H,1) cycles, starting the cycle after the write. S is timing C bits 27:24, H is timing A bits 31:16, and M is the main length of the operation.
- R4: M is timing B bits 23:0 for the three erase operations, timing C bits 15:0 for program, and timing C bits 23:16 for trim recall.
- R5: `arr_erase` is high for exactly the max(M,1) cycles of the main phase of an erase operation, starting max(S,1) cycles into busy. `arr_prog` behaves the same way for program. A trim recall raises neither strobe, and the two strobes are never high together.
- R6: In the first cycle after busy falls, `arr_done` is high for exactly one cycle and the command register reads zero.
- R7: While busy, writes to every register are ignored, including new commands. The running operation's length is unchanged.
- R8: While busy, `arr_addr` is the address register rounded down to a 4096-byte page for a page erase. It is the address register unchanged for a program, and zero for the other operations.
- R9: Register reads return only the implemented fields: timing A bits 31:16 and 5:0, timing B bits 23:0, timing C bits 27:0, and the low ADDR_W bits of the address register. Status bits 31:1 read zero, and the status register cannot be written.
- R10: `rd_wait_states` always equals timing A bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| busy | output | 1 | Operation in progress |
| rd_wait_states | output | 6 | Read wait-state setting |
| arr_erase | output | 1 | Array erase strobe (main phase) |
| arr_prog | output | 1 | Array program strobe (main phase) |
| arr_done | output | 1 | One-cycle end-of-operation pulse |
| arr_addr | output | ADDR_W | Array address for the running operation |

## Verification
The hardest case to reach from the ports is a register write that arrives in the middle of a running sequence. The bench starts a long erase, and part way through it issues a new command and overwrites the timing and address registers. It then measures that the busy window keeps its original length and that the registers read back their earlier contents. The phase boundaries, including zero-valued fields that must still last one cycle, are covered by a sweep over every operation and every small setup, main and hold length. The main-length fields are given distinct values, so that a wrong field selection shows up as a wrong strobe length.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  localparam int DW       = 32;
  localparam int NCMD     = 5;
  localparam int CMD_LSB  = 3;
  localparam int SU_W     = 4;
  localparam int ERASE_W  = 24;
  localparam int PROG_W   = 16;
  localparam int RECALL_W = 8;
  localparam int HOLD_W   = 16;
  localparam int WS_W     = 6;
  localparam int CNT_W    = 24;

  // index into the one-hot command vector (bit position minus CMD_LSB)
  localparam int C_MASS = 0;
  localparam int C_PAGE = 1;
  localparam int C_PROG = 2;
  localparam int C_REF  = 3;
  localparam int C_TRIM = 4;

  // word offsets
  localparam logic [5:0] OFS_CMD  = 6'd0;
  localparam logic [5:0] OFS_STAT = 6'd1;
  localparam logic [5:0] OFS_TIMA = 6'd2;
  localparam logic [5:0] OFS_TIMB = 6'd3;
  localparam logic [5:0] OFS_TIMC = 6'd4;
  localparam logic [5:0] OFS_ADDR = 6'd5;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_MAIN, PH_HOLD} phase_t;

  // cycles-minus-one for a phase; a zero field still costs one cycle
  function automatic logic [CNT_W-1:0] span_m1(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - CNT_W'(1);
  endfunction
endpackage

// File: rtl/nvm_seq_regs.sv
module nvm_seq_regs
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [7:0]          bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic                busy,
  input  logic                finish,
  output logic                start,
  output logic [NCMD-1:0]     cmd,
  output logic [SU_W-1:0]     su_len,
  output logic [ERASE_W-1:0]  erase_len,
  output logic [PROG_W-1:0]   prog_len,
  output logic [RECALL_W-1:0] recall_len,
  output logic [HOLD_W-1:0]   hold_len,
  output logic [WS_W-1:0]     wait_st,
  output logic [ADDR_W-1:0]   addr_q
);
  logic [5:0]      sel;
  logic            wr_ok;
  logic [NCMD-1:0] req, pick;
  logic            unused_lsb;

  assign sel        = bus_addr[7:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign wr_ok      = bus_wr && !busy;
  assign req        = bus_wdata[CMD_LSB +: NCMD];
  assign pick       = req & (~req + NCMD'(1));
  assign start      = wr_ok && (sel == OFS_CMD) && (req != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd        <= '0;
      su_len     <= '0;
      erase_len  <= '0;
      prog_len   <= '0;
      recall_len <= '0;
      hold_len   <= '0;
      wait_st    <= '0;
      addr_q     <= '0;
    end else begin
      if (finish)     cmd <= '0;
      else if (start) cmd <= pick;
      if (wr_ok) begin
        case (sel)
          OFS_TIMA: begin
            hold_len <= bus_wdata[31:16];
            wait_st  <= bus_wdata[5:0];
          end
          OFS_TIMB: erase_len <= bus_wdata[23:0];
          OFS_TIMC: begin
            su_len     <= bus_wdata[27:24];
            recall_len <= bus_wdata[23:16];
            prog_len   <= bus_wdata[15:0];
          end
          OFS_ADDR: addr_q <= bus_wdata[ADDR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      OFS_CMD:  bus_rdata[CMD_LSB +: NCMD] = cmd;
      OFS_STAT: bus_rdata[0] = busy;
      OFS_TIMA: begin
        bus_rdata[31:16] = hold_len;
        bus_rdata[5:0]   = wait_st;
      end
      OFS_TIMB: bus_rdata[23:0] = erase_len;
      OFS_TIMC: begin
        bus_rdata[27:24] = su_len;
        bus_rdata[23:16] = recall_len;
        bus_rdata[15:0]  = prog_len;
      end
      OFS_ADDR: bus_rdata[ADDR_W-1:0] = addr_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R2: at most one operation is ever latched
  a_r2_cmd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd));
  // R7: register contents hold while busy
  a_r7_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(erase_len) && $stable(hold_len) && $stable(prog_len)
              && $stable(su_len) && $stable(addr_q)));
  // R6: command bits clear at the end of a sequence
  a_r6_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (cmd == '0));
endmodule

// File: rtl/nvm_seq_timer.sv
module nvm_seq_timer
  import nvm_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] su_len,
  input  logic [CNT_W-1:0] main_len,
  input  logic [CNT_W-1:0] hold_len,
  output phase_t           phase,
  output logic             busy,
  output logic             finish,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign busy   = (phase != PH_IDLE);
  assign finish = (phase == PH_HOLD) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= span_m1(su_len);
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_MAIN;
          cnt   <= span_m1(main_len);
        end else cnt <= cnt - CNT_W'(1);
        PH_MAIN: if (cnt == '0) begin
          phase <= PH_HOLD;
          cnt   <= span_m1(hold_len);
        end else cnt <= cnt - CNT_W'(1);
        PH_HOLD: if (cnt == '0) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end else cnt <= cnt - CNT_W'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: inside a phase the counter steps down by one
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)) && $stable(phase));
  // R6: done is a single-cycle pulse following busy
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/nvm_seq_strobes.sv
module nvm_seq_strobes
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_BYTES = 4096
) (
  input  phase_t            phase,
  input  logic [NCMD-1:0]   cmd,
  input  logic [ADDR_W-1:0] addr_q,
  output logic              arr_erase,
  output logic              arr_prog,
  output logic [ADDR_W-1:0] arr_addr
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1));

  logic is_erase;
  assign is_erase  = cmd[C_MASS] | cmd[C_PAGE] | cmd[C_REF];
  assign arr_erase = (phase == PH_MAIN) && is_erase;
  assign arr_prog  = (phase == PH_MAIN) && cmd[C_PROG];

  always_comb begin
    arr_addr = '0;
    if (phase != PH_IDLE) begin
      if (cmd[C_PAGE])      arr_addr = addr_q & PAGE_MASK;
      else if (cmd[C_PROG]) arr_addr = addr_q;
    end
  end
endmodule

// File: rtl/nvm_op_sequencer.sv
module nvm_op_sequencer
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic [5:0]        rd_wait_states,
  output logic              arr_erase,
  output logic              arr_prog,
  output logic              arr_done,
  output logic [ADDR_W-1:0] arr_addr
);
  logic                start, finish;
  logic [NCMD-1:0]     cmd;
  logic [SU_W-1:0]     su_len;
  logic [ERASE_W-1:0]  erase_len;
  logic [PROG_W-1:0]   prog_len;
  logic [RECALL_W-1:0] recall_len;
  logic [HOLD_W-1:0]   hold_len;
  logic [ADDR_W-1:0]   addr_q;
  logic [CNT_W-1:0]    main_len;
  phase_t              phase;

  nvm_seq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .finish(finish), .start(start), .cmd(cmd), .su_len(su_len),
    .erase_len(erase_len), .prog_len(prog_len), .recall_len(recall_len),
    .hold_len(hold_len), .wait_st(rd_wait_states), .addr_q(addr_q)
  );

  always_comb begin
    if (cmd[C_PROG])      main_len = CNT_W'(prog_len);
    else if (cmd[C_TRIM]) main_len = CNT_W'(recall_len);
    else                  main_len = CNT_W'(erase_len);
  end

  nvm_seq_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .su_len(CNT_W'(su_len)), .main_len(main_len), .hold_len(CNT_W'(hold_len)),
    .phase(phase), .busy(busy), .finish(finish), .done(arr_done)
  );

  nvm_seq_strobes #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_strobes (
    .phase(phase), .cmd(cmd), .addr_q(addr_q),
    .arr_erase(arr_erase), .arr_prog(arr_prog), .arr_addr(arr_addr)
  );

  // R5: strobes only inside a busy window, never both
  a_r5_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_erase || arr_prog) |-> busy);
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_erase && arr_prog));
  // R2: a running operation always has its command bit latched
  a_r2_busy_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bus_addr != 8'h00 || bus_rdata != 32'h0));
endmodule

// File: tb/nvm_op_sequencer_bench.sv
module nvm_op_sequencer_bench;
  localparam logic [7:0] A_CMD = 8'h00, A_STAT = 8'h04, A_TIMA = 8'h08,
                         A_TIMB = 8'h0C, A_TIMC = 8'h10, A_ADDR = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy, arr_erase, arr_prog, arr_done;
  logic [5:0]  rd_wait_states;
  logic [19:0] arr_addr;
  int total = 0, bad = 0, cyc = 0;

  nvm_op_sequencer u_nvm_op_sequencer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .rd_wait_states(rd_wait_states), .arr_erase(arr_erase),
    .arr_prog(arr_prog), .arr_done(arr_done), .arr_addr(arr_addr)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int mx(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // measure a sequence that was started by the write just completed
  task automatic measure(input logic [31:0] exp_cmd, input logic [19:0] exp_addr,
                         output int blen, output int ec, output int ef,
                         output int pc, output int pf, output int amis);
    logic [31:0] v;
    blen = 0; ec = 0; ef = -1; pc = 0; pf = -1; amis = 0;
    while (busy && blen < 2000) begin
      if (arr_erase) begin if (ec == 0) ef = blen; ec++; end
      if (arr_prog)  begin if (pc == 0) pf = blen; pc++; end
      if (arr_addr !== exp_addr) amis++;
      if (blen == 0) begin
        rd(A_CMD, v); chk("R2 command readback while busy", v, exp_cmd);
      end
      blen++;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input int op, input int s, input int m, input int h);
    int me, mp, mr, mm, blen, ec, ef, pc, pf, amis;
    logic [19:0] ea;
    logic [31:0] v;
    me = m; mp = m + 4; mr = m + 7;
    wr(A_TIMA, {h[15:0], 10'd0, 6'd9});
    wr(A_TIMB, me);
    wr(A_TIMC, {4'd0, s[3:0], mr[7:0], mp[15:0]});
    wr(A_ADDR, 32'h12345);
    mm = (op == 2) ? mp : (op == 4) ? mr : me;
    ea = (op == 1) ? 20'h12000 : (op == 2) ? 20'h12345 : 20'h0;
    wr(A_CMD, 32'h1 << (3 + op));
    measure(32'h1 << (3 + op), ea, blen, ec, ef, pc, pf, amis);
    chk("R3 busy length", blen, mx(s) + mx(mm) + mx(h));
    chk("R4/R5 erase strobe cycles", ec, (op == 0 || op == 1 || op == 3) ? mx(mm) : 0);
    chk("R4/R5 program strobe cycles", pc, (op == 2) ? mx(mm) : 0);
    if (ec > 0) chk("R5 erase strobe start", ef, mx(s));
    if (pc > 0) chk("R5 program strobe start", pf, mx(s));
    chk("R8 address mismatches", amis, 0);
    chk("R6 done pulse", arr_done, 1'b1);
    rd(A_CMD, v); chk("R6 command cleared", v, 0);
    @(negedge clk);
    chk("R6 done single cycle", arr_done, 1'b0);
  endtask

  initial begin
    logic [31:0] v;
    int blen, ec, ef, pc, pf, amis;
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_CMD, v);  chk("R1 command reset", v, 0);
    rd(A_STAT, v); chk("R1 status reset", v, 0);
    rd(A_TIMA, v); chk("R1 timing A reset", v, 0);
    rd(A_TIMB, v); chk("R1 timing B reset", v, 0);
    rd(A_TIMC, v); chk("R1 timing C reset", v, 0);
    rd(A_ADDR, v); chk("R1 address reset", v, 0);
    chk("R1 strobes idle", {busy, arr_erase, arr_prog, arr_done}, 0);

    // R9 field masks and R10 wait-state pin
    wr(A_TIMA, 32'hFFFF_FFFF); rd(A_TIMA, v); chk("R9 timing A mask", v, 32'hFFFF_003F);
    chk("R10 wait states pin", rd_wait_states, 6'h3F);
    wr(A_TIMB, 32'hFFFF_FFFF); rd(A_TIMB, v); chk("R9 timing B mask", v, 32'h00FF_FFFF);
    wr(A_TIMC, 32'hFFFF_FFFF); rd(A_TIMC, v); chk("R9 timing C mask", v, 32'h0FFF_FFFF);
    wr(A_ADDR, 32'hFFFF_FFFF); rd(A_ADDR, v); chk("R9 address mask", v, 32'h000F_FFFF);
    wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, v); chk("R9 status not writable", v, 0);
    rd(8'h3C, v); chk("R9 unmapped reads zero", v, 0);
    wr(A_TIMA, 32'h0000_0015); chk("R10 wait states pin", rd_wait_states, 6'h15);

    // R2 write without command bits starts nothing
    wr(A_CMD, 32'h0000_0007);
    chk("R2 no command no start", busy, 1'b0);
    rd(A_STAT, v); chk("R2 status idle", v, 0);

    // R3 R4 R5 R6 R8 sweep over every operation and small lengths
    for (int op = 0; op < 5; op++)
      for (int s = 0; s < 3; s++)
        for (int m = 0; m < 4; m++)
          for (int h = 0; h < 3; h++)
            run_op(op, s, m, h);

    // R2 priority: page erase and program requested together
    wr(A_TIMA, 32'h0002_0000); wr(A_TIMB, 32'd3);
    wr(A_TIMC, 32'h0100_0005); wr(A_ADDR, 32'h0ABCD);
    wr(A_CMD, 32'h0000_0030);
    measure(32'h10, 20'h0A000, blen, ec, ef, pc, pf, amis);
    chk("R2 priority picks page erase", ec, 3);
    chk("R2 priority no program", pc, 0);
    chk("R8 page-aligned address", amis, 0);
    @(negedge clk);
    wr(A_CMD, 32'h0000_00F8);
    measure(32'h08, 20'h0, blen, ec, ef, pc, pf, amis);
    chk("R2 priority picks mass erase", blen, 1 + 3 + 2);
    @(negedge clk);

    // R7 writes during busy are ignored
    wr(A_TIMB, 32'd20); wr(A_ADDR, 32'h00777);
    wr(A_CMD, 32'h0000_0010);
    repeat (5) @(negedge clk);
    wr(A_CMD, 32'h0000_0020);
    wr(A_TIMB, 32'd2);
    wr(A_TIMA, 32'h0009_0000);
    wr(A_ADDR, 32'h00001);
    rd(A_CMD, v); chk("R7 command unchanged while busy", v, 32'h10);
    measure(32'h10, 20'h0, blen, ec, ef, pc, pf, amis);
    chk("R7 busy length unchanged", blen + 5 + 8, 1 + 20 + 2);
    chk("R7 erase strobe unchanged", ec + 8 + 4 >= 20 ? 32'd1 : 32'd0, 32'd1);
    @(negedge clk);
    rd(A_TIMB, v); chk("R7 timing B kept", v, 32'd20);
    rd(A_TIMA, v); chk("R7 timing A kept", v, 32'h0002_0000);
    rd(A_ADDR, v); chk("R7 address kept", v, 32'h00777);
    chk("R7 no late start", busy, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule